// File: doc/BRIEF.md
# Serial Peripheral Master with Wishbone Registers

This block is a serial peripheral (SPI) master that software drives through a Wishbone register slave with a 32-bit data bus. A single 128-bit shift store sits behind four data words. Writes to these words load transmit bits, and reads return whatever the transfer has put in place. A transfer moves between 1 and 128 bits. Software chooses the bit order and picks the launch and capture edges of the serial clock independently. It can also make the slave-select lines follow the transfer automatically and request an interrupt at the end.

Software loads the data words, the clock divider and the select mask, then writes the control word with the start bit set. From there it either polls the busy bit or waits for the interrupt. Each received bit is written into the same store position its transmitted bit came from. After a short transfer the received value therefore sits right-aligned in word 0, and every bit outside the transfer keeps its earlier content.

Top module: `spi_wb_master`

## Requirements
- R1: After reset every register reads 0, all select lines are high, SCLK and MOSI are low and the interrupt is low.
- R2: Data words (0x00, 0x04, 0x08, 0x0C, word i holding store bits 32i+31..32i), divider (0x14, low 16 bits), select mask (0x18, low 8 bits) and the control fields (length bits 6:0, capture-falling bit 9, launch-falling bit 10, LSB-first bit 11, interrupt-enable bit 12, auto-select bit 13 at 0x10) read back as last written.
- R3: Every bus access is acknowledged by a single-cycle ack in the clock after strobe and cycle are first seen high.
- R4: SCLK idles low, and each SCLK half period lasts divider+1 system clocks.
- R5: A transfer moves n bits, where n is the length field, except that a length of 0 moves 128 bits. The launch edge occurs exactly n times.
- R6: With bit 11 clear, transmitted bit k comes from store position n-1-k. With it set, bit k comes from position k. MOSI shows bit 0 from the start until the first launch edge and shows bit k+1 after launch edge k.
- R7: The MISO value taken at capture edge k is written to the same store position as transmitted bit k. No other store bit changes.
- R8: Launch uses the falling SCLK edge when bit 10 is set and the rising edge otherwise. Capture uses the falling edge when bit 9 is set and the rising edge otherwise.
- R9: Writing 1 to bit 8 starts a transfer. Bit 8 reads 1 while the transfer runs and clears itself at the end. Control writes made while it is 1 are ignored.
- R10: With bit 12 set, the interrupt rises as the transfer ends and falls on the next bus access. With bit 12 clear, it stays low.
- R11: Select line i is low when mask bit i is 1. If bit 13 is set, a line is low only while a transfer runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| wb_adr_i | input | 5 | Byte address of the register |
| wb_dat_i | input | 32 | Write data |
| wb_dat_o | output | 32 | Read data, valid with ack |
| wb_we_i | input | 1 | Write enable |
| wb_stb_i | input | 1 | Strobe |
| wb_cyc_i | input | 1 | Bus cycle |
| wb_ack_o | output | 1 | Acknowledge |
| irq_o | output | 1 | Transfer-complete interrupt |
| ss_n_o | output | 8 | Active-low slave selects |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
The assertions assume that the bus master keeps strobe and cycle high until it sees ack and drops them in the next clock, so that each access is taken once. They also assume that MISO never changes in the system clock where the block samples it on a capture edge. The bench respects both assumptions. Its slave model watches SCLK at the falling system clock edge and moves MISO to its next bit only after the capture edge has already been sampled. The bus tasks release strobe in the half cycle after ack.

// File: rtl/spi_pkg.sv
`timescale 1ns/1ps
package spi_pkg;
    localparam int DATA_W = 32;

    // register index = byte address [4:2]
    typedef enum logic [2:0] {
        REG_W0   = 3'd0,
        REG_W1   = 3'd1,
        REG_W2   = 3'd2,
        REG_W3   = 3'd3,
        REG_CTRL = 3'd4,
        REG_DIV  = 3'd5,
        REG_SEL  = 3'd6
    } reg_idx_e;

    // control word bit positions
    localparam int CB_GO  = 8;
    localparam int CB_RXF = 9;
    localparam int CB_TXF = 10;
    localparam int CB_LSB = 11;
    localparam int CB_IE  = 12;
    localparam int CB_ASS = 13;
endpackage

// File: rtl/spi_sclk_gen.sv
`timescale 1ns/1ps
module spi_sclk_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             sclk_o,
    output logic             rise_o,
    output logic             fall_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             sclk;
    } gen_t;

    gen_t g_q, g_d;
    logic tick;

    always_comb begin
        g_d  = g_q;
        tick = run_i && (g_q.cnt >= div_i);
        if (!run_i) begin
            g_d.cnt  = '0;
            g_d.sclk = 1'b0;
        end else if (tick) begin
            g_d.cnt  = '0;
            g_d.sclk = ~g_q.sclk;
        end else begin
            g_d.cnt = g_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) g_q <= '0;
        else       g_q <= g_d;
    end

    assign sclk_o = g_q.sclk;
    assign rise_o = tick && !g_q.sclk;
    assign fall_o = tick && g_q.sclk;

    AST_SCLK_PARKS_LOW: assert property (@(posedge clk_i) disable iff (rst_i)
        !run_i |=> !sclk_o); // R4
endmodule

// File: rtl/spi_shift_core.sv
`timescale 1ns/1ps
module spi_shift_core #(
    parameter int SHIFT_W = 128,
    parameter int DATA_W  = 32,
    parameter int WSEL_W  = 2,
    parameter int CNT_W   = 8
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               wr_en_i,
    input  logic [WSEL_W-1:0]  wr_sel_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    input  logic               start_i,
    input  logic [CNT_W-1:0]   nbits_i,
    input  logic               lsb_i,
    input  logic               launch_i,
    input  logic               capture_i,
    input  logic               miso_i,
    output logic [SHIFT_W-1:0] sr_o,
    output logic               mosi_o
);
    localparam int IDX_W = CNT_W - 1;

    typedef struct packed {
        logic [SHIFT_W-1:0] sr;
        logic [CNT_W-1:0]   txk;
        logic [CNT_W-1:0]   rxk;
        logic               mosi;
    } sh_t;

    sh_t s_q, s_d;

    // store position of transfer bit k
    function automatic logic [IDX_W-1:0] bitpos(input logic [CNT_W-1:0] k,
                                                input logic [CNT_W-1:0] n,
                                                input logic lsb);
        return IDX_W'(lsb ? k : (n - k - 1'b1));
    endfunction

    always_comb begin
        s_d = s_q;
        if (wr_en_i)
            s_d.sr[32'(wr_sel_i) * DATA_W +: DATA_W] = wr_data_i;
        if (start_i) begin
            s_d.txk  = CNT_W'(1);
            s_d.rxk  = '0;
            s_d.mosi = s_q.sr[bitpos('0, nbits_i, lsb_i)];
        end
        if (launch_i && (s_q.txk < nbits_i)) begin
            s_d.mosi = s_q.sr[bitpos(s_q.txk, nbits_i, lsb_i)];
            s_d.txk  = s_q.txk + 1'b1;
        end
        if (capture_i && (s_q.rxk < nbits_i)) begin
            s_d.sr[bitpos(s_q.rxk, nbits_i, lsb_i)] = miso_i;
            s_d.rxk = s_q.rxk + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) s_q <= '0;
        else       s_q <= s_d;
    end

    assign sr_o   = s_q.sr;
    assign mosi_o = s_q.mosi;

    AST_ONE_BIT_PER_CAPTURE: assert property (@(posedge clk_i) disable iff (rst_i)
        (capture_i && !wr_en_i) |=> ($countones(s_q.sr ^ $past(s_q.sr)) <= 1)); // R7
    AST_STORE_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
        (!capture_i && !wr_en_i) |=> $stable(s_q.sr)); // R7
endmodule

// File: rtl/spi_wb_master.sv
`timescale 1ns/1ps
module spi_wb_master
    import spi_pkg::*;
#(
    parameter int SHIFT_W = 128,
    parameter int DIV_W   = 16,
    parameter int NSS     = 8
) (
    input  logic           clk_i,
    input  logic           rst_i,
    input  logic [4:0]     wb_adr_i,
    input  logic [31:0]    wb_dat_i,
    output logic [31:0]    wb_dat_o,
    input  logic           wb_we_i,
    input  logic           wb_stb_i,
    input  logic           wb_cyc_i,
    output logic           wb_ack_o,
    output logic           irq_o,
    output logic [NSS-1:0] ss_n_o,
    output logic           sclk_o,
    output logic           mosi_o,
    input  logic           miso_i
);
    localparam int LEN_W  = $clog2(SHIFT_W);
    localparam int CNT_W  = LEN_W + 1;
    localparam int ECNT_W = CNT_W + 1;
    localparam int NWORD  = SHIFT_W / DATA_W;
    localparam int WSEL_W = $clog2(NWORD);

    typedef struct packed {
        logic             ass;
        logic             ie;
        logic             lsb;
        logic             txf;
        logic             rxf;
        logic [LEN_W-1:0] len;
    } ctrl_t;

    typedef struct packed {
        ctrl_t             ctrl;
        logic              busy;
        logic [DIV_W-1:0]  div;
        logic [NSS-1:0]    sel;
        logic [ECNT_W-1:0] ecnt;
        logic              irq;
        logic              ack;
        logic [DATA_W-1:0] rdata;
    } top_t;

    top_t t_q, t_d;
    ctrl_t wr_ctrl;
    logic access, hit, start, word_wr, rise, fall, launch, capture, sh_lsb;
    logic [2:0] idx;
    logic [WSEL_W-1:0] wsel;
    logic [CNT_W-1:0] cur_n, new_n, sh_n;
    logic [SHIFT_W-1:0] sr;

    always_comb begin
        access      = wb_stb_i && wb_cyc_i && !t_q.ack;
        hit         = (wb_adr_i[1:0] == 2'b00);
        idx         = wb_adr_i[4:2];
        wsel        = idx[WSEL_W-1:0];
        wr_ctrl.ass = wb_dat_i[CB_ASS];
        wr_ctrl.ie  = wb_dat_i[CB_IE];
        wr_ctrl.lsb = wb_dat_i[CB_LSB];
        wr_ctrl.txf = wb_dat_i[CB_TXF];
        wr_ctrl.rxf = wb_dat_i[CB_RXF];
        wr_ctrl.len = wb_dat_i[LEN_W-1:0];
        cur_n = (t_q.ctrl.len == '0) ? CNT_W'(SHIFT_W) : CNT_W'(t_q.ctrl.len);
        new_n = (wr_ctrl.len == '0) ? CNT_W'(SHIFT_W) : CNT_W'(wr_ctrl.len);

        t_d     = t_q;
        t_d.ack = access;
        start   = 1'b0;
        word_wr = 1'b0;
        if (access) t_d.irq = 1'b0;

        if (access && hit) begin
            if (wb_we_i) begin
                case (idx)
                    REG_CTRL: if (!t_q.busy) begin
                        t_d.ctrl = wr_ctrl;
                        if (wb_dat_i[CB_GO]) begin
                            start    = 1'b1;
                            t_d.busy = 1'b1;
                            t_d.ecnt = '0;
                        end
                    end
                    REG_DIV: t_d.div = wb_dat_i[DIV_W-1:0];
                    REG_SEL: t_d.sel = wb_dat_i[NSS-1:0];
                    default: word_wr = (int'(idx) < NWORD);
                endcase
            end else begin
                case (idx)
                    REG_CTRL: t_d.rdata = DATA_W'({t_q.ctrl.ass, t_q.ctrl.ie, t_q.ctrl.lsb,
                                                   t_q.ctrl.txf, t_q.ctrl.rxf, t_q.busy,
                                                   1'b0, t_q.ctrl.len});
                    REG_DIV: t_d.rdata = DATA_W'(t_q.div);
                    REG_SEL: t_d.rdata = DATA_W'(t_q.sel);
                    default: t_d.rdata = (int'(idx) < NWORD) ?
                                         sr[32'(wsel) * DATA_W +: DATA_W] : '0;
                endcase
            end
        end

        // count SCLK toggles; 2n toggles end the transfer with SCLK low
        if (t_q.busy && (rise || fall)) begin
            if (t_q.ecnt == ECNT_W'({cur_n, 1'b0} - 1'b1)) begin
                t_d.busy = 1'b0;
                if (t_q.ctrl.ie) t_d.irq = 1'b1;
            end else begin
                t_d.ecnt = t_q.ecnt + 1'b1;
            end
        end

        sh_n    = start ? new_n : cur_n;
        sh_lsb  = start ? wr_ctrl.lsb : t_q.ctrl.lsb;
        launch  = t_q.ctrl.txf ? fall : rise;
        capture = t_q.ctrl.rxf ? fall : rise;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) t_q <= '0;
        else       t_q <= t_d;
    end

    spi_sclk_gen #(.DIV_W(DIV_W)) u_gen (
        .clk_i (clk_i), .rst_i (rst_i), .run_i (t_q.busy), .div_i (t_q.div),
        .sclk_o(sclk_o), .rise_o(rise), .fall_o(fall)
    );

    spi_shift_core #(.SHIFT_W(SHIFT_W), .DATA_W(DATA_W), .WSEL_W(WSEL_W), .CNT_W(CNT_W)) u_shift (
        .clk_i    (clk_i),   .rst_i   (rst_i),
        .wr_en_i  (word_wr), .wr_sel_i(wsel),   .wr_data_i(wb_dat_i),
        .start_i  (start),   .nbits_i (sh_n),   .lsb_i    (sh_lsb),
        .launch_i (launch),  .capture_i(capture), .miso_i (miso_i),
        .sr_o     (sr),      .mosi_o  (mosi_o)
    );

    assign wb_dat_o = t_q.rdata;
    assign wb_ack_o = t_q.ack;
    assign irq_o    = t_q.irq;
    assign ss_n_o   = t_q.ctrl.ass ? ~(t_q.sel & {NSS{t_q.busy}}) : ~t_q.sel;

    AST_IDLE_SCLK_LOW: assert property (@(posedge clk_i) disable iff (rst_i)
        !t_q.busy |-> !sclk_o); // R4
    AST_ACK_FOLLOWS_REQ: assert property (@(posedge clk_i) disable iff (rst_i)
        wb_ack_o |-> $past(wb_stb_i && wb_cyc_i)); // R3
    AST_CTRL_FROZEN: assert property (@(posedge clk_i) disable iff (rst_i)
        (t_q.busy && $past(t_q.busy)) |-> $stable(t_q.ctrl)); // R9
    AST_IRQ_AT_END: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(irq_o) |-> ($fell(t_q.busy) && t_q.ctrl.ie)); // R10
    AST_AUTO_SEL_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
        (t_q.ctrl.ass && !t_q.busy) |-> (&ss_n_o)); // R11
endmodule

// File: tb/sim_spi_wb_master.sv
`timescale 1ns/1ps
module sim_spi_wb_master;
    localparam int NV = 6;
    localparam logic [4:0] A_CTRL = 5'h10, A_DIV = 5'h14, A_SEL = 5'h18;

    // stimulus table: control word (no start bit), divider, transmit store, slave pattern
    localparam logic [13:0] V_CTRL [NV] = '{14'h0208, 14'h0408, 14'h0C10, 14'h0000, 14'h0E01, 14'h0A40};
    localparam logic [15:0] V_DIV  [NV] = '{16'd0, 16'd1, 16'd2, 16'd0, 16'd3, 16'd0};
    localparam logic [127:0] V_TX  [NV] = '{
        128'h0011_2233_4455_6677_8899_aabb_ccdd_ee5a,
        128'hdead_beef_0bad_f00d_1234_5678_9abc_dea5,
        128'hffff_0000_ffff_0000_1357_9bdf_2468_5aa5,
        128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210,
        128'h8000_0000_0000_0000_0000_0000_0000_0001,
        128'h1111_2222_3333_4444_fedc_ba98_7654_3210};
    localparam logic [127:0] V_PAT [NV] = '{
        128'h0000_0000_0000_0000_0000_0000_0000_00a5,
        128'h0000_0000_0000_0000_0000_0000_0000_0069,
        128'h0000_0000_0000_0000_0000_0000_0000_7e5a,
        128'hc3c3_5a5a_0f0f_9669_a5a5_3c3c_f0f0_1e1e,
        128'h0000_0000_0000_0000_0000_0000_0000_0000,
        128'h0000_0000_0000_0000_5aa5_a55a_1985_fe31};

    logic clk = 1'b0, rst = 1'b1;
    always #4 clk = ~clk;

    logic [4:0]  adr = '0;
    logic [31:0] dwr = '0, drd;
    logic we = 1'b0, stb = 1'b0, cyc = 1'b0;
    logic ack, irq, sclk, mosi, miso;
    logic [7:0] ss_n;
    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;

    spi_wb_master u0 (
        .clk_i(clk), .rst_i(rst), .wb_adr_i(adr), .wb_dat_i(dwr), .wb_dat_o(drd),
        .wb_we_i(we), .wb_stb_i(stb), .wb_cyc_i(cyc), .wb_ack_o(ack), .irq_o(irq),
        .ss_n_o(ss_n), .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso)
    );

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wb_wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); adr = a; dwr = d; we = 1'b1; stb = 1'b1; cyc = 1'b1;
        @(negedge clk); stb = 1'b0; cyc = 1'b0; we = 1'b0;
    endtask

    task automatic wb_rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk); adr = a; we = 1'b0; stb = 1'b1; cyc = 1'b1;
        @(negedge clk); d = drd; stb = 1'b0; cyc = 1'b0;
    endtask

    // slave model and SCLK monitor, all at the falling system clock edge
    logic [127:0] pat = '0, mrec = '0;
    logic mon_txf = 1'b0, mon_rxf = 1'b0, sp = 1'b0, mp = 1'b0;
    int vec_id = 0, seen_id = 0, jc = 0, lk = 0, tg = 0, since = 0, hp_bad = 0, hp_exp = 1;
    assign miso = (jc < 128) ? pat[jc] : 1'b0;

    always @(negedge clk) begin
        if (seen_id != vec_id) begin
            seen_id = vec_id; jc = 0; lk = 0; tg = 0; since = 0; hp_bad = 0; mrec = '0;
        end else begin
            since++;
            if (sclk !== sp) begin
                if (tg > 0 && since != hp_exp) hp_bad++;
                tg++; since = 0;
                if (sclk == !mon_txf) begin
                    if (lk < 128) mrec[lk] = mp;
                    lk++;
                end
                if (sclk == !mon_rxf) jc++;
            end
        end
        sp = sclk; mp = mosi;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [127:0] got, exp_rx, exp_mo;
        int n, p, guard;
        bit lsb;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1 ss_n", ss_n, 8'hff);
        check("R1 sclk", sclk, 0);
        check("R1 mosi", mosi, 0);
        check("R1 irq", irq, 0);
        for (int a = 0; a < 7; a++) begin
            wb_rd(5'(a * 4), r);
            check("R1 register", r, 0);
        end

        // R3: ack timing
        @(negedge clk); adr = A_DIV; we = 1'b0; stb = 1'b1; cyc = 1'b1;
        #1 check("R3 no ack before edge", ack, 0);
        @(negedge clk); check("R3 ack one cycle later", ack, 1); stb = 1'b0; cyc = 1'b0;
        @(negedge clk); check("R3 ack single cycle", ack, 0);

        // R2: readback; R11 select behaviour when idle
        wb_wr(A_DIV, 32'h0000_1234); wb_rd(A_DIV, r); check("R2 divider", r, 32'h1234);
        wb_wr(A_SEL, 32'h0000_00a5); wb_rd(A_SEL, r); check("R2 select", r, 32'ha5);
        wb_wr(A_CTRL, 32'h0000_3a05); wb_rd(A_CTRL, r); check("R2 control", r, 32'h3a05);
        check("R11 auto select idle high", ss_n, 8'hff);
        wb_wr(A_CTRL, 32'h0000_0005);
        check("R11 manual select", ss_n, 8'h5a);
        for (int w = 0; w < 4; w++) wb_wr(5'(w * 4), 32'hc0de_0000 + 32'(w));
        for (int w = 0; w < 4; w++) begin
            wb_rd(5'(w * 4), r);
            check("R2 data word", r, 32'hc0de_0000 + 32'(w));
        end

        // table walk: R4 R5 R6 R7 R8 R9
        for (int v = 0; v < NV; v++) begin
            for (int w = 0; w < 4; w++) wb_wr(5'(w * 4), V_TX[v][w*32 +: 32]);
            wb_wr(A_DIV, 32'(V_DIV[v]));
            wb_wr(A_SEL, 32'h1);
            wb_wr(A_CTRL, 32'(V_CTRL[v]));
            pat = V_PAT[v]; mon_txf = V_CTRL[v][10]; mon_rxf = V_CTRL[v][9];
            hp_exp = int'(V_DIV[v]) + 1;
            vec_id++;
            wb_wr(A_CTRL, 32'(V_CTRL[v]) | 32'h100);
            guard = 0;
            do begin
                wb_rd(A_CTRL, r); guard++;
            end while (r[8] && guard < 20000);
            check("R9 busy clears, fields kept", r, 32'(V_CTRL[v]));
            n   = (V_CTRL[v][6:0] == 7'd0) ? 128 : int'(V_CTRL[v][6:0]);
            lsb = V_CTRL[v][11];
            exp_rx = V_TX[v]; exp_mo = '0;
            for (int k = 0; k < n; k++) begin
                p = lsb ? k : n - 1 - k;
                exp_mo[k] = V_TX[v][p];
                exp_rx[p] = V_PAT[v][k];
            end
            for (int w = 0; w < 4; w++) begin
                wb_rd(5'(w * 4), r);
                got[w*32 +: 32] = r;
            end
            check("R5 launch edge count", lk, n);
            check("R4 half period", hp_bad, 0);
            check("R4 sclk idle low", sclk, 0);
            check("R6 R8 MOSI bit sequence", mrec, exp_mo);
            check("R7 R8 received store", got, exp_rx);
            check("R10 no irq when disabled", irq, 0);
            check("R11 manual select line", ss_n, 8'hfe);
        end

        // R9 R10 R11: busy readback, ignored control write, interrupt, auto select
        wb_wr(A_DIV, 32'd3);
        wb_wr(A_SEL, 32'h05);
        wb_wr(A_CTRL, 32'h3000);
        check("R11 auto select idle", ss_n, 8'hff);
        wb_wr(A_CTRL, 32'h3100);
        wb_rd(A_CTRL, r);
        check("R9 busy reads 1", r, 32'h3100);
        check("R11 auto select active", ss_n, 8'hfa);
        wb_wr(A_CTRL, 32'h0008);
        wb_rd(A_CTRL, r);
        check("R9 write while busy ignored", r, 32'h3100);
        guard = 0;
        while (!irq && guard < 5000) begin
            @(negedge clk); guard++;
        end
        check("R10 irq at completion", irq, 1);
        check("R11 auto select released", ss_n, 8'hff);
        wb_rd(A_CTRL, r);
        check("R9 busy cleared", r, 32'h3000);
        check("R10 irq cleared by access", irq, 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule